// File: doc/BRIEF.md
# Two-Wire Slave for a Motor-Drive Control Word

This block is a two-wire serial (I2C) slave. It runs on a fast system clock and holds a 16-bit control word for a voice-coil motor stage. The word carries a 10-bit DAC code, a 4-bit time setting and a sleep flag. The block samples the bus clock and data lines through a short synchronizer and finds START and STOP conditions on the synchronized copies. It matches its 7-bit device address and receives writes of two bytes each. It returns the stored word on a read. SDA is driven open-drain: `sda_oe` high means the pad pulls the line low.

The device address is the fixed prefix `00011` followed by the two `addr_sel` pins, so a board can hold up to four of these slaves. In each write pair the high byte comes first. That byte is held in a staging register, and the visible word changes only after the low byte of the same pair is acknowledged. A read shifts out the high byte and then the low byte, and repeats that order for as long as the master keeps acknowledging.

Top module: `vcm_ctrl_i2c`

## Requirements
- R1: After reset, `dac_code`, `time_set` and `sleep_mode` are all 0 and `sda_oe` is 0.
- R2: A STOP (SDA rising while SCL is high) abandons any transfer in progress and releases SDA. A byte cut short by a STOP leaves the outputs unchanged.
- R3: The slave acknowledges an address byte by pulling SDA low for the whole ninth clock only when bits 7..1 equal `0,0,0,1,1,addr_sel[1],addr_sel[0]`. Bit 0 is R/W, where 0 means write and 1 means read. Any other address gets no acknowledge, and the bytes that follow are ignored.
- R4: In a write, every data byte is acknowledged. The first byte of a pair is the high byte and the second is the low byte. The field layout is: `dac_code[9:4]` = high bits 5..0, `sleep_mode` = high bit 7 (high bit 6 is stored but drives nothing), `dac_code[3:0]` = low bits 7..4, and `time_set` = low bits 3..0.
- R5: The outputs change only when the low byte of a pair is acknowledged. A high byte followed by a STOP changes nothing.
- R6: One transaction may carry several byte pairs. Each completed pair becomes visible at its own acknowledge, and the last pair wins.
- R7: A read returns the stored high byte and then the stored low byte, MSB first, and keeps alternating between them while the master acknowledges. After a master NACK the slave releases SDA.
- R8: The slave changes `sda_oe` only while SCL is low, except for the release forced by a START or STOP. Read data is stable while SCL is high.
- R9: A START arriving in the middle of a byte restarts the sequence at the address phase. The partial byte is discarded, and the next byte is taken as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Two low bits of the device address |
| sda_oe | output | 1 | 1 = pull SDA low |
| dac_code | output | 10 | Committed DAC code |
| time_set | output | 4 | Committed time setting |
| sleep_mode | output | 1 | Committed sleep flag, 1 = sleep |

## Verification
Directed writes with known byte values check the field layout. A write to a wrong address shows that the address compare includes the select pins. A lone high byte followed by STOP separates an atomic commit from a byte-wise one. A chain of three pairs checks that each pair commits at its own acknowledge. A START or STOP injected halfway through a byte checks that the bit counter restarts. Random select values, byte values and address hits/misses, each followed by a read-back, check the write path and the read path against one reference word.

// File: rtl/vcm_ctrl_pkg.sv
package vcm_ctrl_pkg;
  localparam int BYTE_W     = 8;
  localparam int SEL_W      = 2;
  localparam int PREFIX_W   = 7 - SEL_W;
  localparam int DAC_W      = 10;
  localparam int TIME_W     = 4;
  localparam int CNT_W      = $clog2(BYTE_W + 1);
  localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b00011;
  localparam logic [CNT_W-1:0]    BITS_FULL   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]    BITS_LAST   = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK
  } bus_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } ctrl_word_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [SEL_W-1:0] sel);
    return b[BYTE_W-1:1] == {ADDR_PREFIX, sel};
  endfunction

  function automatic logic [DAC_W-1:0] dac_of(input ctrl_word_t w);
    return {w.hi[5:0], w.lo[7:4]};
  endfunction

  function automatic logic [TIME_W-1:0] time_of(input ctrl_word_t w);
    return w.lo[3:0];
  endfunction

  function automatic logic sleep_of(input ctrl_word_t w);
    return w.hi[7];
  endfunction

  function automatic logic [BYTE_W-1:0] rd_pick(input ctrl_word_t w, input logic second);
    return second ? w.lo : w.hi;
  endfunction
endpackage

// File: rtl/vcm_line_sync.sv
module vcm_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], raw[g]};
    end
    assign cur[g]  = chain_q[STAGES-1];
    assign prev[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/vcm_bus_engine.sv
module vcm_bus_engine
  import vcm_ctrl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_s,
  input  logic                     sda_s,
  input  logic                     scl_p,
  input  logic                     sda_p,
  input  logic [SEL_W-1:0]         addr_sel,
  input  ctrl_word_t               rd_word,
  output logic                     sda_oe,
  output logic                     wr_ev,
  output logic                     wr_first,
  output logic [BYTE_W-1:0]        wr_data
);
  logic scl_rise, scl_fall, start_ev, stop_ev, addr_ok;
  bus_state_e          state_q;
  logic [CNT_W-1:0]    bitcnt_q;
  logic [BYTE_W-1:0]   sh_q, tx_q, nxt_byte;
  logic                rw_q, pair_q, rd_idx_q, mack_q, oe_q, ev_q, first_q;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign addr_ok  = addr_hit(sh_q, addr_sel);
  assign nxt_byte = rd_pick(rd_word, rd_idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      pair_q   <= 1'b0;
      rd_idx_q <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
      ev_q     <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      ev_q <= 1'b0;
      if (start_ev) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
        pair_q   <= 1'b0;
        rd_idx_q <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise && bitcnt_q < BITS_FULL) begin
              sh_q     <= {sh_q[BYTE_W-2:0], sda_s};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == BITS_FULL) begin
              if (state_q == ST_ADDR) begin
                if (addr_ok) begin
                  oe_q    <= 1'b1;
                  rw_q    <= sh_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                oe_q    <= 1'b1;
                state_q <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (rw_q) begin
                tx_q     <= nxt_byte;
                oe_q     <= ~nxt_byte[BYTE_W-1];
                rd_idx_q <= ~rd_idx_q;
                state_q  <= ST_RD_BYTE;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q     <= 1'b0;
              bitcnt_q <= '0;
              ev_q     <= 1'b1;
              first_q  <= ~pair_q;
              pair_q   <= ~pair_q;
              state_q  <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (bitcnt_q == BITS_LAST) begin
                oe_q    <= 1'b0;
                mack_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q     <= ~tx_q[BYTE_W-2];
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q     <= nxt_byte;
                oe_q     <= ~nxt_byte[BYTE_W-1];
                rd_idx_q <= ~rd_idx_q;
                bitcnt_q <= '0;
                state_q  <= ST_RD_BYTE;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe_q;
  assign wr_ev    = ev_q;
  assign wr_first = first_q;
  assign wr_data  = sh_q;

  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!$past(scl_s) || $past(start_ev || stop_ev)));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev && !start_ev |=> (!oe_q && state_q == ST_IDLE));

  // R7
  rd_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK) |-> !oe_q);

  // R3
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= BITS_FULL);

  // R3
  addr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> oe_q);
endmodule

// File: rtl/vcm_reg_bank.sv
module vcm_reg_bank
  import vcm_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              wr_first,
  input  logic [BYTE_W-1:0] wr_data,
  output ctrl_word_t        word
);
  logic [BYTE_W-1:0] stage_q;
  ctrl_word_t        word_q;
  logic              stage_ev, commit_ev;

  assign stage_ev  = wr_ev & wr_first;
  assign commit_ev = wr_ev & ~wr_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      word_q  <= '0;
    end else begin
      if (stage_ev)  stage_q <= wr_data;
      if (commit_ev) word_q  <= '{hi: stage_q, lo: wr_data};
    end
  end

  assign word = word_q;

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(word_q));
endmodule

// File: rtl/vcm_ctrl_i2c.sv
module vcm_ctrl_i2c
  import vcm_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       addr_sel,
  output logic             sda_oe,
  output logic [9:0]       dac_code,
  output logic [3:0]       time_set,
  output logic             sleep_mode
);
  logic [1:0]        cur, prev;
  logic              wr_ev, wr_first;
  logic [BYTE_W-1:0] wr_data;
  ctrl_word_t        word;

  vcm_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk (clk), .rst_n (rst_n), .raw ({scl_i, sda_i}), .cur (cur), .prev (prev)
  );

  vcm_bus_engine u_engine (
    .clk (clk), .rst_n (rst_n),
    .scl_s (cur[1]), .sda_s (cur[0]), .scl_p (prev[1]), .sda_p (prev[0]),
    .addr_sel (addr_sel), .rd_word (word), .sda_oe (sda_oe),
    .wr_ev (wr_ev), .wr_first (wr_first), .wr_data (wr_data)
  );

  vcm_reg_bank u_bank (
    .clk (clk), .rst_n (rst_n), .wr_ev (wr_ev), .wr_first (wr_first),
    .wr_data (wr_data), .word (word)
  );

  assign dac_code   = dac_of(word);
  assign time_set   = time_of(word);
  assign sleep_mode = sleep_of(word);

  // R1
  reset_idle_chk: assert property (@(posedge clk) $fell(rst_n) |=> (!sda_oe && dac_code == '0));
endmodule

// File: tb/vcm_ctrl_i2c_test.sv
module vcm_ctrl_i2c_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b00;
  logic sda_oe, slp;
  logic [9:0] dac;
  logic [3:0] tset;
  wire sda_line = sda_m & ~sda_oe;

  vcm_ctrl_i2c uut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
    .addr_sel (sel), .sda_oe (sda_oe), .dac_code (dac), .time_set (tset),
    .sleep_mode (slp)
  );

  int vectors = 0, miscmp = 0;
  logic [7:0] ref_hi = 8'h00, ref_lo = 8'h00;

  function automatic logic [9:0] want_dac(input logic [7:0] h, input logic [7:0] l);
    return 10'((h & 8'h3f) * 16 + (l >> 4));
  endfunction
  function automatic logic [3:0] want_time(input logic [7:0] l);
    return 4'(l & 8'h0f);
  endfunction
  function automatic logic [6:0] dev7(input logic [1:0] s);
    return 7'h0c + 7'(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk(req, 32'(dac), 32'(want_dac(ref_hi, ref_lo)));
    chk(req, 32'(tset), 32'(want_time(ref_lo)));
    chk(req, 32'(slp), 32'(ref_hi[7]));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    scl_m = 1'b0; wait_clk(4);
    sda_m = b;    wait_clk(4);
    scl_m = 1'b1; wait_clk(8);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    logic early;
    scl_m = 1'b0; sda_m = 1'b1; wait_clk(8);
    scl_m = 1'b1; wait_clk(3);
    early = sda_line; wait_clk(4);
    b = sda_line;
    chk("R8 read bit stable while SCL high", 32'(b), 32'(early));
    wait_clk(1);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b1; wait_clk(4);
    scl_m = 1'b1; wait_clk(8);
    sda_m = 1'b0; wait_clk(8);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b0; wait_clk(4);
    scl_m = 1'b1; wait_clk(8);
    sda_m = 1'b1; wait_clk(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b1; wait_clk(4);
    scl_m = 1'b1; wait_clk(4);
    ack = ~sda_line; wait_clk(4);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      d[i] = b;
    end
    put_bit(nack);
  endtask

  task automatic write_pair(input logic [1:0] s, input logic [7:0] h, input logic [7:0] l,
                            input string req);
    logic ack;
    bus_start();
    send_byte({dev7(s), 1'b0}, ack);
    chk({req, " address ack"}, 32'(ack), 32'(s == sel));
    send_byte(h, ack);
    if (s == sel) chk("R4 high byte ack", 32'(ack), 32'd1);
    send_byte(l, ack);
    if (s == sel) chk("R4 low byte ack", 32'(ack), 32'd1);
    else          chk("R3 no ack after wrong address", 32'(ack), 32'd0);
    bus_stop();
    if (s == sel) begin ref_hi = h; ref_lo = l; end
  endtask

  task automatic read_back(input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({dev7(sel), 1'b1}, ack);
    chk("R3 read address ack", 32'(ack), 32'd1);
    recv_byte(1'b0, d); chk({req, " high byte"}, 32'(d), 32'(ref_hi));
    recv_byte(1'b0, d); chk({req, " low byte"}, 32'(d), 32'(ref_lo));
    recv_byte(1'b1, d); chk({req, " wrap to high"}, 32'(d), 32'(ref_hi));
    wait_clk(6);
    chk("R7 release after NACK", 32'(sda_oe), 32'd0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'h1f3a_7c05));
    wait_clk(5);
    chk("R1 reset sda_oe", 32'(sda_oe), 32'd0);
    chk_outputs("R1 reset outputs");
    rst_n = 1'b1;
    wait_clk(5);

    // R4 directed field layout
    sel = 2'b01;
    write_pair(2'b01, 8'h8a, 8'h5c, "R3");
    wait_clk(4);
    chk_outputs("R4 field layout");
    chk("R4 dac value", 32'(dac), 32'h0a5);

    // R3 wrong address ignored
    write_pair(2'b10, 8'h3f, 8'hff, "R3 wrong address");
    chk_outputs("R3 wrong address leaves outputs");

    // R5 partial write
    bus_start();
    send_byte({dev7(sel), 1'b0}, ack);
    send_byte(8'h01, ack);
    bus_stop();
    chk_outputs("R5 lone high byte");

    // R6 several pairs in one transaction
    bus_start();
    send_byte({dev7(sel), 1'b0}, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    wait_clk(6);
    ref_hi = 8'h11; ref_lo = 8'h22;
    chk_outputs("R6 first pair committed mid-transaction");
    send_byte(8'h33, ack);
    wait_clk(6);
    chk_outputs("R6 high byte of second pair not visible");
    send_byte(8'h44, ack);
    send_byte(8'hc7, ack); send_byte(8'h9e, ack);
    bus_stop();
    ref_hi = 8'hc7; ref_lo = 8'h9e;
    chk_outputs("R6 last pair wins");

    // R7 readback
    read_back("R7 readback");

    // R9 START in the middle of a byte
    bus_start();
    send_byte({dev7(sel), 1'b0}, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    send_byte({dev7(sel), 1'b0}, ack);
    chk("R9 address after repeated start", 32'(ack), 32'd1);
    send_byte(8'h05, ack); send_byte(8'h60, ack);
    bus_stop();
    ref_hi = 8'h05; ref_lo = 8'h60;
    chk_outputs("R9 pair after restart");

    // R2 STOP in the middle of a byte
    bus_start();
    send_byte({dev7(sel), 1'b0}, ack);
    send_byte(8'hff, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_stop();
    wait_clk(4);
    chk("R2 released after stop", 32'(sda_oe), 32'd0);
    chk_outputs("R2 cut byte ignored");

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [1:0] s;
      sel = 2'($urandom);
      s = (($urandom % 4) == 0) ? (sel ^ 2'(1 + $urandom % 3)) : sel;
      write_pair(s, 8'($urandom), 8'($urandom), "R3 random");
      chk_outputs("R4 random write");
      read_back("R7 random readback");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule